// File: doc/BRIEF.md
# Word-Copy DMA Engine

This block is a small bus master that moves 32-bit words from one address range to another under software control. Software loads a source address, a destination address and a word count through a byte-addressed register port. Writing the count starts the move. For each word the engine issues a read on its master port, waits for the returned data, optionally reverses the four bytes of the word, and writes it to the destination. Both addresses step by four after every word. When the last destination write is accepted, an interrupt-pending bit is raised and drives the interrupt output until software acknowledges it.

Two further registers serve as a simple query mechanism. A command write places either a fixed identification word or a frame-timing flag in a result register. The timing flag compares a free-running cycle counter with a deadline, and a vertical-blank pulse moves that deadline to the current count plus a programmable delay. Register reads are combinational on the register address.

Top module: `wcdma_top`

## Requirements
- R1: After reset, irq is 0, the master port requests nothing, and reads of the status byte (0x0C), the config byte (0x0E) and the result register (0x14) return 0.
- R2: A non-zero write to the count register (0x08) while idle copies that many words. Word k is read from source+4k and written to destination+4k, reads and writes alternate, and exactly count writes occur.
- R3: When bit 7 of the config byte at 0x0E is 1, each word is written with byte 0 and byte 3 exchanged and byte 1 and byte 2 exchanged. When the bit is 0, the word is written unchanged. A read of 0x0E returns the byte last written.
- R4: Status byte 0x0C has busy at bit 7 and pending at bit 0. Busy is 1 from the cycle after the count write until the last destination write is accepted. Pending and irq become 1 in the cycle after that acceptance, and irq always equals pending.
- R5: Writing 0x0D with bit 0 set clears pending and irq in the next cycle. Writing 0x0D with bit 0 clear has no effect.
- R6: While busy, writes to 0x00, 0x04 and 0x08 are ignored. The running copy keeps its addresses and count, and no new copy starts.
- R7: A zero count written while idle sets pending and irq in the next cycle with no master request.
- R8: A write to the command register (0x10) with bit 29 set loads the result register with 0x16C311DB. This holds whatever the value of bit 31.
- R9: A command write with bit 31 set and bit 29 clear loads the result with 0x00000000 if the cycle count has reached the deadline, and with 0xFFFFFFFF if it has not. A command write with both bits clear leaves the result unchanged.
- R10: A vblank pulse sets the deadline to the current cycle count plus status_delay. The deadline is 0 after reset.
- R11: Any write to 0x14 loads the result with 0xFFFFFFFF, whatever the data.
- R12: If an acknowledge write and a completion (last write accepted, or zero-count start) occur in the same cycle, pending ends up set.
- R13: A master request holds its address, direction and write data until m_req_ready is 1. Read data is taken in the cycle where m_rsp_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte address |
| reg_wdata | input | 32 | Register write data (byte registers use bits 7:0) |
| reg_rdata | output | 32 | Register read data for reg_addr |
| vblank | input | 1 | Vertical-blank pulse; re-arms the timing deadline |
| status_delay | input | DLY_W | Cycles from vblank until the deadline |
| m_req_valid | output | 1 | Master request valid |
| m_req_write | output | 1 | 1 = write request, 0 = read request |
| m_req_addr | output | ADDR_W | Master byte address |
| m_req_wdata | output | 32 | Master write data |
| m_req_ready | input | 1 | Request accepted by memory |
| m_rsp_valid | input | 1 | Read data valid |
| m_rsp_rdata | input | 32 | Read data |
| irq | output | 1 | Interrupt, equal to the pending bit |

## Verification
Completion of a copy and a software acknowledge can land on the same clock edge. The first sets pending and the second clears it. The bench watches the master port and, at the falling edge before the final write is accepted, issues the acknowledge write, so both events meet on one rising edge. It then judges the result against its own cycle model, in which the new completion wins, and confirms that irq stays high until a later acknowledge.

// File: rtl/wcdma_pkg.sv
package wcdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD    = 2'd1,
      ST_RWAIT = 2'd2,
      ST_WR    = 2'd3
   } eng_state_t;

   localparam int REG_AW = 5;

   localparam logic [REG_AW-1:0] A_SRC  = 5'h00;
   localparam logic [REG_AW-1:0] A_DST  = 5'h04;
   localparam logic [REG_AW-1:0] A_LEN  = 5'h08;
   localparam logic [REG_AW-1:0] A_STAT = 5'h0C;
   localparam logic [REG_AW-1:0] A_ACK  = 5'h0D;
   localparam logic [REG_AW-1:0] A_CFG  = 5'h0E;
   localparam logic [REG_AW-1:0] A_CMD  = 5'h10;
   localparam logic [REG_AW-1:0] A_RES  = 5'h14;

   localparam logic [31:0] ID_WORD  = 32'h16C3_11DB;
   localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;

   localparam int SWAP_BIT     = 7;
   localparam int CMD_ID_BIT   = 29;
   localparam int CMD_STAT_BIT = 31;

   function automatic logic [31:0] bswap32(input logic [31:0] w);
      return {w[7:0], w[15:8], w[23:16], w[31:24]};
   endfunction

endpackage

// File: rtl/wcdma_deadline.sv
module wcdma_deadline
   import wcdma_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int DLY_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vblank,
   input  logic [DLY_W-1:0] delay,
   output logic             passed
);

   generate
      if (DLY_W < 1 || DLY_W > CNT_W) begin : g_bad_dly
         $error("wcdma_deadline: DLY_W must be in 1..CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] due_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         due_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
         if (vblank) due_q <= cnt_q + CNT_W'(delay);
      end
   end

   assign passed = (cnt_q >= due_q);

   // a delay of two or more cycles cannot have expired one cycle after the pulse
   assert_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vblank && (delay > DLY_W'(1)) |=> !passed);

endmodule

// File: rtl/wcdma_engine.sv
module wcdma_engine
   import wcdma_pkg::*;
#(
   parameter int AW      = 32,
   parameter int LW      = 32,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_src,
   input  logic          ld_dst,
   input  logic          ld_len,
   input  logic [31:0]   wdata,
   input  logic          cfg_swap,
   output logic          m_req_valid,
   output logic          m_req_write,
   output logic [AW-1:0] m_req_addr,
   output logic [31:0]   m_req_wdata,
   input  logic          m_req_ready,
   input  logic          m_rsp_valid,
   input  logic [31:0]   m_rsp_rdata,
   output logic          busy,
   output logic          done
);

   localparam logic [AW-1:0] STEP = AW'(4);
   localparam logic [LW-1:0] ONE  = LW'(1);

   generate
      if (AW < 3 || AW > 32) begin : g_bad_aw
         $error("wcdma_engine: AW must be in 3..32");
      end
      if (LW < 1 || LW > 32) begin : g_bad_lw
         $error("wcdma_engine: LW must be in 1..32");
      end
   endgenerate

   eng_state_t    st_q;
   logic [AW-1:0] src_q, dst_q;
   logic [LW-1:0] len_q;
   logic [31:0]   word_q;
   logic [31:0]   rd_word;

   generate
      if (SWAP_EN) begin : g_swap
         assign rd_word = cfg_swap ? bswap32(m_rsp_rdata) : m_rsp_rdata;
      end else begin : g_noswap
         assign rd_word = m_rsp_rdata;
      end
   endgenerate

   logic idle, wr_acc, last_acc, zero_start;
   assign idle       = (st_q == ST_IDLE);
   assign wr_acc     = (st_q == ST_WR) && m_req_ready;
   assign last_acc   = wr_acc && (len_q == ONE);
   assign zero_start = idle && ld_len && (wdata[LW-1:0] == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         word_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (ld_src) src_q <= wdata[AW-1:0];
               if (ld_dst) dst_q <= wdata[AW-1:0];
               if (ld_len) begin
                  len_q <= wdata[LW-1:0];
                  if (wdata[LW-1:0] != '0) st_q <= ST_RD;
               end
            end
            ST_RD: begin
               if (m_req_ready) st_q <= ST_RWAIT;
            end
            ST_RWAIT: begin
               if (m_rsp_valid) begin
                  word_q <= rd_word;
                  st_q   <= ST_WR;
               end
            end
            ST_WR: begin
               if (m_req_ready) begin
                  src_q <= src_q + STEP;
                  dst_q <= dst_q + STEP;
                  len_q <= len_q - ONE;
                  st_q  <= (len_q == ONE) ? ST_IDLE : ST_RD;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign m_req_valid = (st_q == ST_RD) || (st_q == ST_WR);
   assign m_req_write = (st_q == ST_WR);
   assign m_req_addr  = m_req_write ? dst_q : src_q;
   assign m_req_wdata = word_q;
   assign busy        = !idle;
   assign done        = zero_start || last_acc;

   assert_hold_req_R13: assert property (@(posedge clk) disable iff (!rst_n)
      m_req_valid && !m_req_ready |=>
         m_req_valid && $stable(m_req_addr) && $stable(m_req_write) && $stable(m_req_wdata));

   assert_zero_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && ld_len && (wdata[LW-1:0] == '0) |=> !m_req_valid && !busy);

   assert_locked_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ld_src && !(m_req_valid && m_req_write && m_req_ready) |=> $stable(src_q));

   assert_locked_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy && ld_len && !(m_req_valid && m_req_write && m_req_ready) |=> $stable(len_q));

endmodule

// File: rtl/wcdma_regfile.sv
module wcdma_regfile
   import wcdma_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        wbyte,
   input  logic              cmd_id,
   input  logic              cmd_stat,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic              done,
   input  logic              deadline_passed,
   output logic              ld_src,
   output logic              ld_dst,
   output logic              ld_len,
   output logic              cfg_swap,
   output logic              irq
);

   logic [7:0]  cfg_q;
   logic        pend_q;
   logic [31:0] res_q;
   logic        ack_hit, cmd_wr, res_wr;

   assign ld_src  = reg_wr && (reg_addr == A_SRC);
   assign ld_dst  = reg_wr && (reg_addr == A_DST);
   assign ld_len  = reg_wr && (reg_addr == A_LEN);
   assign ack_hit = reg_wr && (reg_addr == A_ACK) && wbyte[0];
   assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
   assign res_wr  = reg_wr && (reg_addr == A_RES);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         pend_q <= 1'b0;
         res_q  <= '0;
      end else begin
         if (reg_wr && (reg_addr == A_CFG)) cfg_q <= wbyte;
         // a completion in the same cycle as an acknowledge is kept
         if (done)         pend_q <= 1'b1;
         else if (ack_hit) pend_q <= 1'b0;
         if (res_wr) res_q <= ALL_ONES;
         else if (cmd_wr) begin
            if (cmd_id)        res_q <= ID_WORD;
            else if (cmd_stat) res_q <= deadline_passed ? 32'h0 : ALL_ONES;
         end
      end
   end

   always_comb begin
      unique case (reg_addr)
         A_STAT:  reg_rdata = {24'h0, busy, 6'h0, pend_q};
         A_CFG:   reg_rdata = {24'h0, cfg_q};
         A_RES:   reg_rdata = res_q;
         default: reg_rdata = 32'h0;
      endcase
   end

   assign cfg_swap = cfg_q[SWAP_BIT];
   assign irq      = pend_q;

   assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq);

   assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit && !done |=> !irq);

   assert_collide_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ack_hit && done |=> irq);

   assert_id_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr && cmd_id |=> reg_addr != A_RES || reg_rdata == ID_WORD);

   assert_res_wr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      res_wr |=> res_q == ALL_ONES);

endmodule

// File: rtl/wcdma_top.sv
module wcdma_top
   import wcdma_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int LEN_W   = 32,
   parameter int CNT_W   = 32,
   parameter int DLY_W   = 16,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              vblank,
   input  logic [DLY_W-1:0]  status_delay,
   output logic              m_req_valid,
   output logic              m_req_write,
   output logic [ADDR_W-1:0] m_req_addr,
   output logic [31:0]       m_req_wdata,
   input  logic              m_req_ready,
   input  logic              m_rsp_valid,
   input  logic [31:0]       m_rsp_rdata,
   output logic              irq
);

   logic ld_src, ld_dst, ld_len, cfg_swap, busy, done, passed;

   wcdma_regfile u_regs (
      .clk             (clk),
      .rst_n           (rst_n),
      .reg_wr          (reg_wr),
      .reg_addr        (reg_addr),
      .wbyte           (reg_wdata[7:0]),
      .cmd_id          (reg_wdata[CMD_ID_BIT]),
      .cmd_stat        (reg_wdata[CMD_STAT_BIT]),
      .reg_rdata       (reg_rdata),
      .busy            (busy),
      .done            (done),
      .deadline_passed (passed),
      .ld_src          (ld_src),
      .ld_dst          (ld_dst),
      .ld_len          (ld_len),
      .cfg_swap        (cfg_swap),
      .irq             (irq)
   );

   wcdma_engine #(
      .AW      (ADDR_W),
      .LW      (LEN_W),
      .SWAP_EN (SWAP_EN)
   ) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .ld_src      (ld_src),
      .ld_dst      (ld_dst),
      .ld_len      (ld_len),
      .wdata       (reg_wdata),
      .cfg_swap    (cfg_swap),
      .m_req_valid (m_req_valid),
      .m_req_write (m_req_write),
      .m_req_addr  (m_req_addr),
      .m_req_wdata (m_req_wdata),
      .m_req_ready (m_req_ready),
      .m_rsp_valid (m_rsp_valid),
      .m_rsp_rdata (m_rsp_rdata),
      .busy        (busy),
      .done        (done)
   );

   wcdma_deadline #(
      .CNT_W (CNT_W),
      .DLY_W (DLY_W)
   ) u_deadline (
      .clk    (clk),
      .rst_n  (rst_n),
      .vblank (vblank),
      .delay  (status_delay),
      .passed (passed)
   );

   assert_finish_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

endmodule

// File: tb/wcdma_top_tb_top.sv
`timescale 1ns/1ps
module wcdma_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        vblank = 1'b0;
   logic [15:0] status_delay = '0;
   logic        m_req_valid, m_req_write, m_req_ready;
   logic [31:0] m_req_addr, m_req_wdata;
   logic        m_rsp_valid = 1'b0;
   logic [31:0] m_rsp_rdata = '0;
   logic        irq;

   always #2.5 clk = ~clk;

   wcdma_top dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vblank(vblank),
      .status_delay(status_delay), .m_req_valid(m_req_valid),
      .m_req_write(m_req_write), .m_req_addr(m_req_addr),
      .m_req_wdata(m_req_wdata), .m_req_ready(m_req_ready),
      .m_rsp_valid(m_rsp_valid), .m_rsp_rdata(m_rsp_rdata), .irq(irq)
   );

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit stall   = 1'b0;
   bit run_chk = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // memory model
   logic [31:0] mem [64];
   assign m_req_ready = !(stall && (cyc % 3 == 1));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (m_req_valid && m_req_ready && m_req_write) mem[m_req_addr[7:2]] <= m_req_wdata;
      m_rsp_valid <= m_req_valid && m_req_ready && !m_req_write;
      m_rsp_rdata <= mem[m_req_addr[7:2]];
   end

   // reference model
   logic [31:0] e_waddr [16];
   logic [31:0] e_wdata [16];
   logic [31:0] e_raddr [16];
   int e_len = 0, wi = 0, ri = 0, m_wcnt = 0;
   bit m_busy = 1'b0, e_pend = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 1'b0; e_pend = 1'b0; m_wcnt = 0;
      end else begin
         automatic bit ack = reg_wr && reg_addr == 5'h0D && reg_wdata[0];
         automatic bit acc = m_req_valid && m_req_ready && m_req_write;
         automatic bit fin = acc && m_busy && (m_wcnt + 1 == e_len);
         automatic bit zs  = reg_wr && reg_addr == 5'h08 && reg_wdata == 0 && !m_busy;
         if (acc) m_wcnt++;
         if (fin || zs) e_pend = 1'b1;
         else if (ack)  e_pend = 1'b0;
         if (fin) m_busy = 1'b0;
         else if (reg_wr && reg_addr == 5'h08 && reg_wdata != 0 && !m_busy) begin
            m_busy = 1'b1; m_wcnt = 0;
         end
      end
   end

   // per-cycle comparison
   always @(negedge clk) begin
      if (run_chk) begin
         chk(irq === e_pend, "R4 irq vs model pending", {31'h0, irq}, {31'h0, e_pend});
         chk(m_busy || !m_req_valid, "R7 no master traffic while idle", {31'h0, m_req_valid}, 32'h0);
         if (m_req_valid && m_req_ready) begin
            if (m_req_write) begin
               chk(m_req_addr == e_waddr[wi % 16], "R2/R6 write address", m_req_addr, e_waddr[wi % 16]);
               chk(m_req_wdata == e_wdata[wi % 16], "R3 write data", m_req_wdata, e_wdata[wi % 16]);
               wi++;
            end else begin
               chk(m_req_addr == e_raddr[ri % 16], "R2 read address", m_req_addr, e_raddr[ri % 16]);
               ri++;
            end
         end
      end
   end

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog R2 actual=%0d expected=<20000", cyc);
         summary();
         $finish;
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic start(input logic [31:0] s, input logic [31:0] dd, input int n, input bit sw);
      wi = 0; ri = 0; e_len = n;
      for (int k = 0; k < n; k++) begin
         automatic logic [31:0] w = mem[(s >> 2) + k];
         e_raddr[k] = s + 4 * k;
         e_waddr[k] = dd + 4 * k;
         e_wdata[k] = sw ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
      end
      wr(5'h00, s);
      wr(5'h04, dd);
      wr(5'h08, n);
   endtask

   task automatic wait_irq();
      while (!irq) @(negedge clk);
   endtask

   logic [31:0] v;

   initial begin
      for (int k = 0; k < 64; k++) mem[k] = 32'hA1B2_0000 + k * 32'h0001_0103;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_chk = 1'b1;

      // R1 reset state
      rd(5'h0C, v); chk(v == 0, "R1 status after reset", v, 0);
      rd(5'h0E, v); chk(v == 0, "R1 config after reset", v, 0);
      rd(5'h14, v); chk(v == 0, "R1 result after reset", v, 0);
      chk(!irq && !m_req_valid, "R1 irq and master idle", {30'h0, irq, m_req_valid}, 0);

      // R2 plain copy, no stalls
      start(32'h00, 32'h80, 4, 1'b0);
      rd(5'h0C, v); chk(v == 32'h80, "R4 busy after count write", v, 32'h80);
      wait_irq();
      rd(5'h0C, v); chk(v == 32'h01, "R4 pending and not busy at end", v, 32'h01);
      chk(wi == 4 && ri == 4, "R2 word count", wi, 4);
      for (int k = 0; k < 4; k++) chk(mem[32 + k] == mem[k], "R2 destination memory", mem[32 + k], mem[k]);

      // R5 acknowledge
      wr(5'h0D, 32'h0000_00FE);
      chk(irq == 1'b1, "R5 ack with bit0 clear ignored", {31'h0, irq}, 1);
      wr(5'h0D, 32'h0000_0001);
      chk(irq == 1'b0, "R5 ack clears irq", {31'h0, irq}, 0);

      // R3 swap, R13 stalls, R6 writes while busy
      wr(5'h0E, 32'h80);
      rd(5'h0E, v); chk(v == 32'h80, "R3 config readback", v, 32'h80);
      stall = 1'b1;
      start(32'h10, 32'hC0, 3, 1'b1);
      wr(5'h00, 32'h100);
      wr(5'h04, 32'h1F0);
      wr(5'h08, 32'h7);
      wait_irq();
      chk(wi == 3 && ri == 3, "R6 busy writes ignored, word count", wi, 3);
      for (int k = 0; k < 3; k++) begin
         automatic logic [31:0] w = mem[4 + k];
         chk(mem[48 + k] == {w[7:0], w[15:8], w[23:16], w[31:24]}, "R3 swapped memory under R13 stalls",
             mem[48 + k], {w[7:0], w[15:8], w[23:16], w[31:24]});
      end
      repeat (3) @(negedge clk);
      chk(!m_req_valid, "R6 no restart after finish", {31'h0, m_req_valid}, 0);
      stall = 1'b0;
      wr(5'h0E, 32'h00);
      wr(5'h0D, 32'h1);

      // R7 zero-length
      e_len = 0;
      wr(5'h08, 32'h0);
      chk(irq == 1'b1, "R7 zero count raises irq", {31'h0, irq}, 1);
      wr(5'h0D, 32'h1);

      // R12 acknowledge collides with completion
      start(32'h20, 32'hE0, 2, 1'b0);
      while (!(m_req_valid && m_req_write && m_req_ready && m_wcnt == e_len - 1)) @(negedge clk);
      wr(5'h0D, 32'h1);
      chk(irq == 1'b1, "R12 completion wins over ack", {31'h0, irq}, 1);
      for (int k = 0; k < 2; k++) chk(mem[56 + k] == mem[8 + k], "R12 copy intact", mem[56 + k], mem[8 + k]);
      wr(5'h0D, 32'h1);
      chk(irq == 1'b0, "R12 later ack clears", {31'h0, irq}, 0);

      // R8 identification
      wr(5'h10, 32'h2000_0000);
      rd(5'h14, v); chk(v == 32'h16C3_11DB, "R8 id word", v, 32'h16C3_11DB);
      wr(5'h14, 32'h0);
      wr(5'h10, 32'hA000_0000);
      rd(5'h14, v); chk(v == 32'h16C3_11DB, "R8 id with bit31 also set", v, 32'h16C3_11DB);

      // R9 / R10 timing status
      wr(5'h10, 32'h8000_0000);
      rd(5'h14, v); chk(v == 32'h0, "R9 deadline passed after reset", v, 0);
      status_delay = 16'd20;
      vblank = 1'b1; @(negedge clk); vblank = 1'b0;
      wr(5'h10, 32'h8000_0000);
      rd(5'h14, v); chk(v == 32'hFFFF_FFFF, "R10 deadline not yet reached", v, 32'hFFFF_FFFF);
      wr(5'h10, 32'h0000_0000);
      rd(5'h14, v); chk(v == 32'hFFFF_FFFF, "R9 command without bits unchanged", v, 32'hFFFF_FFFF);
      repeat (25) @(negedge clk);
      wr(5'h10, 32'h8000_0000);
      rd(5'h14, v); chk(v == 32'h0, "R10 deadline reached", v, 0);

      // R11 result write
      wr(5'h14, 32'h1234_5678);
      rd(5'h14, v); chk(v == 32'hFFFF_FFFF, "R11 result write forces ones", v, 32'hFFFF_FFFF);

      repeat (2) @(negedge clk);
      run_chk = 1'b0;
      summary();
      $finish;
   end

endmodule